// File: doc/BRIEF.md
# Timeslot Exchange Event Timer

This block times the radio events of one two-way exchange inside a fixed-length timeslot. A microsecond tick enable paces two counters. The first counts from the start-of-slot pulse. The second counts from the start of the slot and is re-armed at the accepted end of the data frame. From these counts the block issues single-cycle strobes: receiver enable, transmit start, receive timeout and acknowledgement transmit.

The role is sampled at each start-of-slot pulse, together with a slot-in-use flag. As initiator, the block starts the data transmission at a fixed offset. After the data frame ends, it opens the receiver shortly before the acknowledgement is due and gives up after a bounded window. As responder, the block opens the receiver early and waits a bounded time for a frame to begin. It then schedules the acknowledgement a fixed delay after the data frame ends. A new start-of-slot pulse always aborts the current sequence, and the end of the slot drops any event still pending.

Top module: `slot_event_timer`

## Requirements
- R1: After reset, and before any start-of-slot pulse, all four strobes stay low.
- R2: In an initiator slot, `tx_start_o` pulses once, in the cycle after the clock edge that samples the 2120th tick following the start-of-slot pulse.
- R3: In a responder slot, `rx_en_o` pulses once, in the cycle after the edge that samples the 1020th tick after slot start.
- R4: In a responder slot with no `rx_start_i` after the receiver opens, `rx_timeout_o` pulses after the 3220th tick. If a frame start arrives first, there is no timeout.
- R5: In a responder slot, after a frame has started, `ack_tx_o` pulses after the 1000th tick that follows the edge sampling `frame_end_i`.
- R6: In an initiator slot, after the `frame_end_i` that follows the transmission, `rx_en_o` pulses after the 900th tick. If no `rx_start_i` arrives, `rx_timeout_o` pulses after the 1300th tick.
- R7: In an initiator slot, an `rx_start_i` while waiting for the acknowledgement suppresses the timeout.
- R8: Every strobe is one cycle wide, and at most one strobe is high in any cycle.
- R9: A start-of-slot pulse aborts any pending event, and timing restarts from that pulse.
- R10: A slot started with `role_i` equal to 2'b00 or 2'b11, or with `slot_used_i` low, produces no strobe. Role encoding: 2'b01 initiator, 2'b10 responder.
- R11: Once 10000 ticks have elapsed since slot start, the sequence ends and no further strobe appears until the next start-of-slot pulse.
- R12: Time advances only on clock edges where `tick_i` is high. Spacing the ticks apart delays every event by the same number of ticks, not cycles.
- R13: Changes to `role_i` or `slot_used_i` after the start-of-slot pulse have no effect on the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond tick enable |
| slot_start_i | input | 1 | Start-of-slot pulse |
| role_i | input | 2 | 01 initiator, 10 responder, others idle |
| slot_used_i | input | 1 | Slot carries an exchange for this node |
| rx_start_i | input | 1 | Radio detected the start of an incoming frame |
| frame_end_i | input | 1 | Current data frame finished |
| rx_en_o | output | 1 | Receiver enable strobe |
| tx_start_o | output | 1 | Data transmit start strobe |
| rx_timeout_o | output | 1 | Receive window expired strobe |
| ack_tx_o | output | 1 | Acknowledgement transmit strobe |

## Verification
The bench builds the block with its default template values, a 10000-microsecond slot and the standard offsets, so every strobe position is checked at its true tick count. Ticks arrive on every cycle in most scenarios, which keeps a full slot to about 10000 cycles. This makes the slot-end cut-off and late frame ends reachable in one run. One scenario spaces the ticks two cycles apart, which separates tick counting from cycle counting.

// File: rtl/slot_evt_pkg.sv
package slot_evt_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF  = 2'b00,
    ROLE_INIT = 2'b01,
    ROLE_RESP = 2'b10,
    ROLE_RSVD = 2'b11
  } role_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_I_TX,
    ST_I_DATA,
    ST_I_ACK_ON,
    ST_I_ACK_WAIT,
    ST_R_RX_ON,
    ST_R_SFD,
    ST_R_DATA,
    ST_R_ACK,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic rx_en;
    logic tx_start;
    logic rx_timeout;
    logic ack_tx;
  } strobes_t;

endpackage

// File: rtl/slot_evt_tick_cnt.sv
module slot_evt_tick_cnt #(
  parameter int W   = 14,
  parameter int MAX = 10000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = W'(MAX);

  logic [W-1:0] cnt_q;

  // clear wins over a coincident tick; saturate at MAX
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/slot_evt_seq.sv
module slot_evt_seq
  import slot_evt_pkg::*;
#(
  parameter int SLOT_US      = 10000,
  parameter int TX_OFS_US    = 2120,
  parameter int RX_OFS_US    = 1020,
  parameter int RX_WAIT_US   = 2200,
  parameter int ACK_DLY_US   = 1000,
  parameter int ACK_GUARD_US = 100,
  parameter int ACK_WAIT_US  = 400,
  parameter int CNT_W        = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             slot_start_i,
  input  logic [1:0]       role_i,
  input  logic             slot_used_i,
  input  logic             rx_start_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] slot_cnt_i,
  input  logic [CNT_W-1:0] rel_cnt_i,
  output logic             rel_clr_o,
  output strobes_t         strb_o
);

  localparam int RX_TMO_US  = RX_OFS_US + RX_WAIT_US;
  localparam int ACK_RX_US  = ACK_DLY_US - ACK_GUARD_US;
  localparam int ACK_TMO_US = ACK_RX_US + ACK_WAIT_US;

  seq_state_e state_q, state_d;
  strobes_t   strb_q, strb_d;

  // true on the edge that samples the t-th tick
  function automatic logic at_tick(input logic tk, input logic [CNT_W-1:0] c, input int t);
    return tk && (c == CNT_W'(t - 1));
  endfunction

  logic slot_over;
  assign slot_over = at_tick(tick_i, slot_cnt_i, SLOT_US);

  always_comb begin
    state_d = state_q;
    strb_d  = '0;
    if (slot_start_i) begin
      if (slot_used_i && role_i == ROLE_INIT)      state_d = ST_I_TX;
      else if (slot_used_i && role_i == ROLE_RESP) state_d = ST_R_RX_ON;
      else                                         state_d = ST_IDLE;
    end else if (state_q != ST_IDLE && slot_over) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_I_TX: if (at_tick(tick_i, rel_cnt_i, TX_OFS_US)) begin
          strb_d.tx_start = 1'b1;
          state_d = ST_I_DATA;
        end
        ST_I_DATA: if (frame_end_i) state_d = ST_I_ACK_ON;
        ST_I_ACK_ON: if (at_tick(tick_i, rel_cnt_i, ACK_RX_US)) begin
          strb_d.rx_en = 1'b1;
          state_d = ST_I_ACK_WAIT;
        end
        ST_I_ACK_WAIT: begin
          if (rx_start_i) state_d = ST_DONE;
          else if (at_tick(tick_i, rel_cnt_i, ACK_TMO_US)) begin
            strb_d.rx_timeout = 1'b1;
            state_d = ST_DONE;
          end
        end
        ST_R_RX_ON: if (at_tick(tick_i, rel_cnt_i, RX_OFS_US)) begin
          strb_d.rx_en = 1'b1;
          state_d = ST_R_SFD;
        end
        ST_R_SFD: begin
          if (rx_start_i) state_d = ST_R_DATA;
          else if (at_tick(tick_i, rel_cnt_i, RX_TMO_US)) begin
            strb_d.rx_timeout = 1'b1;
            state_d = ST_DONE;
          end
        end
        ST_R_DATA: if (frame_end_i) state_d = ST_R_ACK;
        ST_R_ACK: if (at_tick(tick_i, rel_cnt_i, ACK_DLY_US)) begin
          strb_d.ack_tx = 1'b1;
          state_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // relative timer restarts at slot start and at an accepted frame end
  assign rel_clr_o = slot_start_i ||
                     (frame_end_i && (state_q == ST_I_DATA || state_q == ST_R_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      strb_q  <= '0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
    end
  end

  assign strb_o = strb_q;

endmodule

// File: rtl/slot_event_timer.sv
module slot_event_timer
  import slot_evt_pkg::*;
#(
  parameter int SLOT_US      = 10000,
  parameter int TX_OFS_US    = 2120,
  parameter int RX_OFS_US    = 1020,
  parameter int RX_WAIT_US   = 2200,
  parameter int ACK_DLY_US   = 1000,
  parameter int ACK_GUARD_US = 100,
  parameter int ACK_WAIT_US  = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       slot_start_i,
  input  logic [1:0] role_i,
  input  logic       slot_used_i,
  input  logic       rx_start_i,
  input  logic       frame_end_i,
  output logic       rx_en_o,
  output logic       tx_start_o,
  output logic       rx_timeout_o,
  output logic       ack_tx_o
);

  localparam int CNT_W = $clog2(SLOT_US + 1);

  logic [CNT_W-1:0] slot_cnt, rel_cnt;
  logic             rel_clr;
  strobes_t         strb;

  slot_evt_tick_cnt #(.W(CNT_W), .MAX(SLOT_US)) u_slot_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (slot_start_i),
    .tick_i (tick_i),
    .cnt_o  (slot_cnt)
  );

  slot_evt_tick_cnt #(.W(CNT_W), .MAX(SLOT_US)) u_rel_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rel_clr),
    .tick_i (tick_i),
    .cnt_o  (rel_cnt)
  );

  slot_evt_seq #(
    .SLOT_US      (SLOT_US),
    .TX_OFS_US    (TX_OFS_US),
    .RX_OFS_US    (RX_OFS_US),
    .RX_WAIT_US   (RX_WAIT_US),
    .ACK_DLY_US   (ACK_DLY_US),
    .ACK_GUARD_US (ACK_GUARD_US),
    .ACK_WAIT_US  (ACK_WAIT_US),
    .CNT_W        (CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .slot_start_i (slot_start_i),
    .role_i       (role_i),
    .slot_used_i  (slot_used_i),
    .rx_start_i   (rx_start_i),
    .frame_end_i  (frame_end_i),
    .slot_cnt_i   (slot_cnt),
    .rel_cnt_i    (rel_cnt),
    .rel_clr_o    (rel_clr),
    .strb_o       (strb)
  );

  assign rx_en_o      = strb.rx_en;
  assign tx_start_o   = strb.tx_start;
  assign rx_timeout_o = strb.rx_timeout;
  assign ack_tx_o     = strb.ack_tx;

endmodule

// File: rtl/slot_event_timer_chk.sv
module slot_event_timer_chk #(
  parameter int SLOT_US   = 10000,
  parameter int TX_OFS_US = 2120
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       slot_start_i,
  input logic [1:0] role_i,
  input logic       slot_used_i,
  input logic       rx_en_o,
  input logic       tx_start_o,
  input logic       rx_timeout_o,
  input logic       ack_tx_o
);

  localparam int CW = $clog2(SLOT_US + 1);

  logic [CW-1:0] ticks_q;
  logic          armed_q;
  logic [1:0]    role_q;
  logic [3:0]    strb;

  assign strb = {rx_en_o, tx_start_o, rx_timeout_o, ack_tx_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ticks_q <= '0;
      armed_q <= 1'b0;
      role_q  <= 2'b00;
    end else if (slot_start_i) begin
      ticks_q <= '0;
      armed_q <= slot_used_i && (role_i == 2'b01 || role_i == 2'b10);
      role_q  <= role_i;
    end else if (tick_i && ticks_q != CW'(SLOT_US)) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  // R8
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb));

  // R8
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb != 4'b0) |=> ((strb & $past(strb)) == 4'b0));

  // R9
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_i |=> (strb == 4'b0));

  // R10
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (strb == 4'b0));

  // R2
  tx_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (ticks_q == CW'(TX_OFS_US)));

  // R11
  slot_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ticks_q == CW'(SLOT_US)) |-> (strb == 4'b0));

  // R13
  role_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o |-> role_q == 2'b01) and (ack_tx_o |-> role_q == 2'b10));

endmodule

bind slot_event_timer slot_event_timer_chk #(
  .SLOT_US   (SLOT_US),
  .TX_OFS_US (TX_OFS_US)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .slot_start_i (slot_start_i),
  .role_i       (role_i),
  .slot_used_i  (slot_used_i),
  .rx_en_o      (rx_en_o),
  .tx_start_o   (tx_start_o),
  .rx_timeout_o (rx_timeout_o),
  .ack_tx_o     (ack_tx_o)
);

// File: tb/slot_event_timer_tb.sv
module slot_event_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       slot_start = 1'b0;
  logic [1:0] role = 2'b00;
  logic       slot_used = 1'b0;
  logic       rx_start = 1'b0;
  logic       frame_end = 1'b0;
  logic       rx_en, tx_start, rx_timeout, ack_tx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slot_event_timer u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .slot_start_i (slot_start),
    .role_i       (role),
    .slot_used_i  (slot_used),
    .rx_start_i   (rx_start),
    .frame_end_i  (frame_end),
    .rx_en_o      (rx_en),
    .tx_start_o   (tx_start),
    .rx_timeout_o (rx_timeout),
    .ack_tx_o     (ack_tx)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc, fe_at, fs_at, chg_at;
  bit gap;
  int first [4];
  int hits  [4];
  int dbl, multi;
  logic [3:0] prev;

  localparam int I_RX = 0, I_TX = 1, I_TO = 2, I_ACK = 3;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic drive_for_cyc();
    frame_end = (cyc == fe_at);
    rx_start  = (cyc == fs_at);
    tick      = gap ? (cyc % 2 == 1) : 1'b1;
    if (cyc == chg_at) begin
      role      = 2'b00;
      slot_used = 1'b0;
    end
  endtask

  task automatic sample();
    logic [3:0] s;
    s = {ack_tx, rx_timeout, tx_start, rx_en};
    for (int i = 0; i < 4; i++) begin
      if (s[i]) begin
        hits[i]++;
        if (first[i] < 0) first[i] = cyc;
        if (prev[i]) dbl++;
      end
    end
    if ($countones(s) > 1) multi++;
    prev = s;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    sample();
    drive_for_cyc();
  endtask

  task automatic start_slot(input logic [1:0] r, input logic used);
    @(negedge clk);
    slot_start = 1'b1;
    role       = r;
    slot_used  = used;
    frame_end  = 1'b0;
    rx_start   = 1'b0;
    tick       = gap ? 1'b0 : 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    cyc   = 0;
    dbl   = 0;
    multi = 0;
    prev  = '0;
    for (int i = 0; i < 4; i++) begin
      first[i] = -1;
      hits[i]  = 0;
    end
    sample();
    drive_for_cyc();
  endtask

  task automatic setup(input int fe, input int fs);
    fe_at  = fe;
    fs_at  = fs;
    chg_at = -1;
    gap    = 1'b0;
  endtask

  task automatic shape_ok(input string tag);
    chk({tag, " R8 width"}, dbl, 0);
    chk({tag, " R8 overlap"}, multi, 0);
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rx_en || tx_start || rx_timeout || ack_tx) seen++;
    end
    chk("R1 strobes after reset", seen, 0);
  endtask

  task automatic t_init_ack();
    setup(2500, 3450);
    start_slot(2'b01, 1'b1);
    repeat (4000) step();
    chk("R2 tx_start cycle", first[I_TX], 2120);
    chk("R2 tx_start count", hits[I_TX], 1);
    chk("R6 ack rx_en cycle", first[I_RX], 2501 + 900);
    chk("R7 no timeout", hits[I_TO], 0);
    chk("R7 no ack_tx as initiator", hits[I_ACK], 0);
    shape_ok("init_ack");
  endtask

  task automatic t_init_timeout();
    setup(2500, -1);
    start_slot(2'b01, 1'b1);
    repeat (4000) step();
    chk("R6 rx_en cycle", first[I_RX], 3401);
    chk("R6 timeout cycle", first[I_TO], 2501 + 1300);
    chk("R6 timeout count", hits[I_TO], 1);
    shape_ok("init_to");
  endtask

  task automatic t_resp_ack();
    setup(2000, 1500);
    start_slot(2'b10, 1'b1);
    repeat (3500) step();
    chk("R3 rx_en cycle", first[I_RX], 1020);
    chk("R4 no timeout after frame start", hits[I_TO], 0);
    chk("R5 ack_tx cycle", first[I_ACK], 2001 + 1000);
    chk("R5 no tx_start as responder", hits[I_TX], 0);
    shape_ok("resp_ack");
  endtask

  task automatic t_resp_timeout();
    setup(3500, -1);
    start_slot(2'b10, 1'b1);
    repeat (5000) step();
    chk("R4 timeout cycle", first[I_TO], 3220);
    chk("R4 no ack after timeout", hits[I_ACK], 0);
    shape_ok("resp_to");
  endtask

  task automatic t_idle(input logic [1:0] r, input logic used, input string tag);
    setup(2500, 1500);
    start_slot(r, used);
    repeat (4000) step();
    chk({"R10 ", tag}, hits[0] + hits[1] + hits[2] + hits[3], 0);
  endtask

  task automatic t_gap();
    setup(-1, -1);
    gap = 1'b1;
    start_slot(2'b01, 1'b1);
    repeat (4500) step();
    chk("R12 tx_start with spaced ticks", first[I_TX], 2 * 2120);
    gap = 1'b0;
  endtask

  task automatic t_abort();
    setup(-1, -1);
    start_slot(2'b01, 1'b1);
    repeat (2000) step();
    start_slot(2'b10, 1'b1);
    repeat (3500) step();
    chk("R9 aborted tx_start absent", hits[I_TX], 0);
    chk("R9 restarted rx_en cycle", first[I_RX], 1020);
    chk("R9 restarted timeout cycle", first[I_TO], 3220);
  endtask

  task automatic t_role_change();
    setup(-1, -1);
    chg_at = 10;
    start_slot(2'b10, 1'b1);
    repeat (3500) step();
    chk("R13 rx_en despite role change", first[I_RX], 1020);
    chk("R13 timeout despite role change", first[I_TO], 3220);
  endtask

  task automatic t_slot_end();
    setup(9500, 3000);
    start_slot(2'b10, 1'b1);
    repeat (10800) step();
    chk("R11 rx_en before end", first[I_RX], 1020);
    chk("R11 late ack dropped", hits[I_ACK], 0);
    chk("R11 no timeout", hits[I_TO], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    setup(-1, -1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init_ack();
    t_init_timeout();
    t_resp_ack();
    t_resp_timeout();
    t_idle(2'b00, 1'b1, "role 00");
    t_idle(2'b11, 1'b1, "role 11");
    t_idle(2'b01, 1'b0, "unused slot");
    t_gap();
    t_abort();
    t_role_change();
    t_slot_end();
    finish_run();
  end

endmodule